// File: doc/BRIEF.md
# Falling-Edge Phase Comparator with Filtered Lock Indicator

This block sits in the speed loop of a motor controller. It takes a reference clock and a tachometer pulse train. Both are asynchronous to the system clock. The block compares only the falling edges of the two signals. When the loop is in control, the tachometer runs at the same frequency as the reference. Each comparison yields one pump pulse on either `pump_up` or `pump_dn`, and the width of that pulse in system clock cycles equals the edge separation. A downstream analog filter and error amplifier, which are not part of this block, turn the pulse duty into a torque command.

Lock is judged from the same pulses. A comparison whose pulse is shorter than a programmable threshold counts as locked. A pulse that reaches the threshold, whether finished or still open, counts as unlocked. The raw lock level passes through an asymmetric deglitcher before it drives the active-low `lock_n` output. With `mask_sel` high, a lock must persist for `mask_cycles` system cycles before it is shown, and an unlock is shown at once. With `mask_sel` low the roles swap: short unlock episodes are swallowed and a lock is shown at once. A `mask_cycles` of zero turns masking off.

Top module: `phase_lock_cmp`

## Requirements
- R1: While reset is held and in the first cycle after it, `pump_up` and `pump_dn` are 0 and `lock_n` is 1.
- R2: When a falling edge of `ref_in` precedes a falling edge of `fb_in` by N system cycles, `pump_up` is high for exactly N cycles and `pump_dn` stays low.
- R3: When a falling edge of `fb_in` precedes a falling edge of `ref_in` by N cycles, `pump_dn` is high for exactly N cycles and `pump_up` stays low.
- R4: Falling edges arriving in the same cycle produce no pump pulse, and rising edges never start or end one.
- R5: `pump_up` and `pump_dn` are never high together.
- R6: A comparison whose pulse width is below `lock_thresh` sets the raw lock level. A pulse width of `lock_thresh` or more clears it.
- R7: `lock_n` is active low. With `mask_cycles` equal to 0 it follows the raw lock level one cycle later, in both directions.
- R8: With `mask_sel` = 1, a raw lock lasting fewer than `mask_cycles` cycles never drives `lock_n` low, and a sustained lock drives it low `mask_cycles` cycles after it begins. A raw unlock drives `lock_n` high on the next cycle.
- R9: With `mask_sel` = 0, a raw unlock lasting fewer than `mask_cycles` cycles never drives `lock_n` high, and a sustained unlock drives it high. A raw lock drives `lock_n` low on the next cycle.
- R10: If the trailing edge of a comparison never arrives, the open pump pulse stays high. The lock level clears as soon as the open pulse has lasted `lock_thresh` cycles, without waiting for the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Reference clock, asynchronous, falling edge is the timing point |
| fb_in | input | 1 | Tachometer pulse train, asynchronous, falling edge is the timing point |
| mask_cycles | input | MASK_W | Deglitch time in system cycles; 0 disables masking |
| lock_thresh | input | WIDTH_W | Pulse width, in cycles, at which a comparison counts as unlocked |
| mask_sel | input | 1 | 1: swallow short lock episodes; 0: swallow short unlock episodes |
| pump_up | output | 1 | High while the reference edge leads |
| pump_dn | output | 1 | High while the tachometer edge leads |
| lock_n | output | 1 | Filtered lock indicator, low when locked |

## Verification
The assertions assume that `mask_cycles`, `mask_sel` and `lock_thresh` change only while reset is held. The mask-off and immediate-direction properties compare `lock_n` with the raw lock level one cycle earlier, so they would misfire if a setting moved mid-run. The stimulus programs all three settings before each reset is released and does not touch them until the next reset. The reference and tachometer are driven at the falling system clock edge with at most one falling edge each per period. Every edge separation also stays well inside a period, so each pump pulse closes before the next comparison begins.

// File: rtl/pcl_pkg.sv
// Package: shared types for the phase comparator and lock filter.
// Assumes: nothing beyond IEEE 1800-2017.
package pcl_pkg;

    // Phase detector state: which pump, if any, is currently driven.
    typedef enum logic [1:0] {
        PUMP_IDLE = 2'd0,
        PUMP_UP   = 2'd1,
        PUMP_DN   = 2'd2
    } pump_state_e;

endpackage

// File: rtl/pcl_edge_sync.sv
// Module: pcl_edge_sync
// Brings an asynchronous level into the clock domain through STAGES flops.
// It then emits a one-cycle strobe on each falling edge.
// Assumes: the input pulse widths exceed STAGES+1 clock cycles; the input
// idles low out of reset (a high level after reset only shows a rising
// edge, which is ignored).
module pcl_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall
);

    logic [STAGES:0] chain;

    // Shift the input through the synchronizer and the edge-history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-1:0], din};
        end
    end

    // Falling edge: previous synchronized level high, current level low.
    always_comb begin
        fall = chain[STAGES] & ~chain[STAGES-1];
    end

endmodule

// File: rtl/pcl_phase_det.sv
// Module: pcl_phase_det
// Tri-state falling-edge phase detector. A leading reference edge opens an
// up pulse, a leading feedback edge opens a down pulse, and the other
// edge closes the pulse. Edges arriving together leave it idle.
// `done` strobes in the cycle a comparison completes.
// Assumes: edge strobes are single-cycle and synchronous to clk.
module pcl_phase_det
    import pcl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_fall,
    input  logic fb_fall,
    output logic pump_up,
    output logic pump_dn,
    output logic done
);

    pump_state_e state_q;
    pump_state_e state_d;

    // Next-state and completion decode from the two edge strobes.
    always_comb begin
        state_d = state_q;
        done    = 1'b0;
        if (ref_fall && fb_fall) begin
            state_d = PUMP_IDLE;
            done    = 1'b1;
        end else if (ref_fall) begin
            if (state_q == PUMP_DN) begin
                state_d = PUMP_IDLE;
                done    = 1'b1;
            end else begin
                state_d = PUMP_UP;
            end
        end else if (fb_fall) begin
            if (state_q == PUMP_UP) begin
                state_d = PUMP_IDLE;
                done    = 1'b1;
            end else begin
                state_d = PUMP_DN;
            end
        end
    end

    // Hold the detector state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PUMP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Pump outputs decoded from the registered state.
    always_comb begin
        pump_up = (state_q == PUMP_UP);
        pump_dn = (state_q == PUMP_DN);
    end

endmodule

// File: rtl/pcl_lock_judge.sv
// Module: pcl_lock_judge
// Measures each pump pulse and derives the raw lock level. A finished
// pulse shorter than `thresh` means locked. A pulse, open or finished,
// that reaches `thresh` means unlocked.
// Assumes: `thresh` is static outside reset; `done` coincides with the last
// active pump cycle, or with an idle cycle for coincident edges.
module pcl_lock_judge #(
    parameter int WIDTH_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic               done,
    input  logic [WIDTH_W-1:0] thresh,
    output logic               raw_lock
);

    localparam logic [WIDTH_W-1:0] CNT_MAX = '1;

    logic [WIDTH_W-1:0] cnt_q;
    logic [WIDTH_W:0]   width_now;
    logic [WIDTH_W:0]   width_done;
    logic [WIDTH_W:0]   thresh_x;

    // Pulse width including the current cycle; zero for coincident edges.
    always_comb begin
        width_now  = {1'b0, cnt_q} + {{WIDTH_W{1'b0}}, 1'b1};
        width_done = active ? width_now : '0;
        thresh_x   = {1'b0, thresh};
    end

    // Count active cycles and update the raw lock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            raw_lock <= 1'b0;
        end else if (done) begin
            cnt_q    <= '0;
            raw_lock <= (width_done < thresh_x);
        end else if (active) begin
            if (cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (width_now >= thresh_x) begin
                raw_lock <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pcl_mask_filter.sv
// Module: pcl_mask_filter
// Asymmetric deglitcher. One transition direction, chosen by `sel`, must
// hold for `mask` cycles before it reaches the output. The other direction
// passes after one cycle. sel=1 delays lock; sel=0 delays unlock.
// A mask of 0 or 1 passes both directions after one cycle.
// Assumes: `sel` and `mask` are static outside reset.
module pcl_mask_filter #(
    parameter int MASK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raw,
    input  logic              sel,
    input  logic [MASK_W-1:0] mask,
    output logic              filt
);

    logic [MASK_W-1:0] cnt_q;
    logic [MASK_W:0]   held;
    logic              pass_now;

    // Cycles the raw level has disagreed, including this one; and whether
    // the pending transition is the unmasked direction.
    always_comb begin
        held     = {1'b0, cnt_q} + {{MASK_W{1'b0}}, 1'b1};
        pass_now = (raw != sel);
    end

    // Track disagreement time and move the output when it is due.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            filt  <= 1'b0;
        end else if (raw == filt) begin
            cnt_q <= '0;
        end else if (pass_now || (held >= {1'b0, mask})) begin
            cnt_q <= '0;
            filt  <= raw;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/phase_lock_cmp.sv
// Module: phase_lock_cmp (top)
// Falling-edge phase comparator with pump outputs and a masked, active-low
// lock indicator.
// Assumes: ref_in and fb_in are asynchronous with pulse widths longer than
// SYNC_STAGES+1 clock cycles; configuration inputs change only in reset.
module phase_lock_cmp #(
    parameter int MASK_W      = 16,
    parameter int WIDTH_W     = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_in,
    input  logic               fb_in,
    input  logic [MASK_W-1:0]  mask_cycles,
    input  logic [WIDTH_W-1:0] lock_thresh,
    input  logic               mask_sel,
    output logic               pump_up,
    output logic               pump_dn,
    output logic               lock_n
);

    logic ref_fall;
    logic fb_fall;
    logic cmp_done;
    logic pump_active;
    logic raw_lock;
    logic lock_filt;

    pcl_edge_sync #(.STAGES(SYNC_STAGES)) ref_sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ref_in),
        .fall  (ref_fall)
    );

    pcl_edge_sync #(.STAGES(SYNC_STAGES)) fb_sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (fb_in),
        .fall  (fb_fall)
    );

    pcl_phase_det det_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_fall (ref_fall),
        .fb_fall  (fb_fall),
        .pump_up  (pump_up),
        .pump_dn  (pump_dn),
        .done     (cmp_done)
    );

    // Either pump running means a comparison is open.
    always_comb begin
        pump_active = pump_up | pump_dn;
    end

    pcl_lock_judge #(.WIDTH_W(WIDTH_W)) judge_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (pump_active),
        .done     (cmp_done),
        .thresh   (lock_thresh),
        .raw_lock (raw_lock)
    );

    pcl_mask_filter #(.MASK_W(MASK_W)) mask_i (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (raw_lock),
        .sel   (mask_sel),
        .mask  (mask_cycles),
        .filt  (lock_filt)
    );

    // Lock indicator is active low.
    always_comb begin
        lock_n = ~lock_filt;
    end

endmodule

// File: rtl/pcl_checker.sv
// Module: pcl_checker
// Temporal properties of phase_lock_cmp, attached by bind.
// Assumes: configuration inputs are static outside reset.
module pcl_checker #(
    parameter int MASK_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pump_up,
    input logic              pump_dn,
    input logic              lock_n,
    input logic              raw_lock,
    input logic              mask_sel,
    input logic [MASK_W-1:0] mask_cycles
);

    // R5
    pumps_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pump_up && pump_dn));

    // R7
    mask_off_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_cycles == '0) |=> (lock_n == !$past(raw_lock)));

    // R8
    unlock_immediate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_sel && !raw_lock) |=> lock_n);

    // R9
    lock_immediate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_sel && raw_lock) |=> !lock_n);

    // R6
    lock_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_n) |-> $past(raw_lock));

endmodule

bind phase_lock_cmp pcl_checker #(.MASK_W(MASK_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pump_up     (pump_up),
    .pump_dn     (pump_dn),
    .lock_n      (lock_n),
    .raw_lock    (raw_lock),
    .mask_sel    (mask_sel),
    .mask_cycles (mask_cycles)
);

// File: tb/phase_lock_cmp_tb_top.sv
// Directed bench for phase_lock_cmp: one task per scenario.
module phase_lock_cmp_tb_top;

    localparam int MASK_W  = 16;
    localparam int WIDTH_W = 12;
    localparam int PER     = 100;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               ref_in = 1'b0;
    logic               fb_in = 1'b0;
    logic [MASK_W-1:0]  mask_cycles = '0;
    logic [WIDTH_W-1:0] lock_thresh = '0;
    logic               mask_sel = 1'b1;
    logic               pump_up;
    logic               pump_dn;
    logic               lock_n;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    phase_lock_cmp #(.MASK_W(MASK_W), .WIDTH_W(WIDTH_W), .SYNC_STAGES(2)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_in      (ref_in),
        .fb_in       (fb_in),
        .mask_cycles (mask_cycles),
        .lock_thresh (lock_thresh),
        .mask_sel    (mask_sel),
        .pump_up     (pump_up),
        .pump_dn     (pump_dn),
        .lock_n      (lock_n)
    );

    // Record one check and report a mismatch.
    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Program the settings under reset, then release it.
    task automatic do_reset(input int mask, input bit sel, input int thr);
        @(negedge clk);
        rst_n       = 1'b0;
        ref_in      = 1'b0;
        fb_in       = 1'b0;
        mask_cycles = MASK_W'(mask);
        mask_sel    = sel;
        lock_thresh = WIDTH_W'(thr);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One comparison period; each input is high on [rise, fall).
    task automatic period_run(input int rr, input int rf, input int fr, input int ff,
                              output int up_n, output int dn_n,
                              output int low_n, output int both_n);
        up_n = 0; dn_n = 0; low_n = 0; both_n = 0;
        for (int c = 0; c < PER; c++) begin
            @(negedge clk);
            up_n   += int'(pump_up);
            dn_n   += int'(pump_dn);
            low_n  += int'(!lock_n);
            both_n += int'(pump_up && pump_dn);
            ref_in = (c >= rr) && (c < rf);
            fb_in  = (c >= fr) && (c < ff);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "pump_up in reset", int'(pump_up), 0);
        check("R1", "pump_dn in reset", int'(pump_dn), 0);
        check("R1", "lock_n in reset", int'(lock_n), 1);
        do_reset(0, 1'b1, 8);
        @(negedge clk);
        check("R1", "lock_n after reset", int'(lock_n), 1);
    endtask

    task automatic t_ref_lead;
        int u, d, l, b;
        do_reset(0, 1'b1, 8);
        period_run(10, 40, 10, 45, u, d, l, b);
        check("R2", "up width skew 5", u, 5);
        check("R2", "dn width skew 5", d, 0);
        period_run(10, 40, 10, 60, u, d, l, b);
        check("R2", "up width skew 20", u, 20);
    endtask

    task automatic t_fb_lead;
        int u, d, l, b;
        do_reset(0, 1'b1, 8);
        period_run(10, 50, 10, 38, u, d, l, b);
        check("R3", "dn width skew 12", d, 12);
        check("R3", "up width skew 12", u, 0);
    endtask

    task automatic t_coincident;
        int u, d, l, b;
        do_reset(0, 1'b1, 8);
        period_run(5, 40, 20, 40, u, d, l, b);
        check("R4", "up on coincident falls", u, 0);
        check("R4", "dn on coincident falls", d, 0);
        period_run(10, 40, 10, 70, u, d, l, b);
        check("R5", "both pumps high", b, 0);
    endtask

    task automatic t_lock_basic;
        int u, d, l, b;
        do_reset(0, 1'b1, 8);
        period_run(10, 40, 10, 43, u, d, l, b);
        check("R7", "lock_n after skew 3", int'(lock_n), 0);
        period_run(10, 40, 10, 47, u, d, l, b);
        check("R6", "lock_n after skew 7", int'(lock_n), 0);
        period_run(10, 40, 10, 48, u, d, l, b);
        check("R6", "lock_n after skew 8", int'(lock_n), 1);
        period_run(10, 40, 10, 42, u, d, l, b);
        check("R7", "lock_n after skew 2", int'(lock_n), 0);
    endtask

    task automatic t_timeout;
        int u, d, l, b;
        do_reset(0, 1'b1, 8);
        period_run(10, 40, 10, 42, u, d, l, b);
        check("R10", "locked before stall", int'(lock_n), 0);
        period_run(10, 40, 10, PER, u, d, l, b);
        check("R10", "pump_up held open", int'(pump_up), 1);
        check("R10", "lock_n after stall", int'(lock_n), 1);
    endtask

    task automatic t_mask_lock;
        int u, d, l, b, l2;
        do_reset(250, 1'b1, 8);
        period_run(10, 40, 10, 42, u, d, l, b);
        period_run(10, 40, 10, 70, u, d, l2, b);
        check("R8", "short lock swallowed", l + l2, 0);
        period_run(10, 40, 10, 42, u, d, l, b);
        period_run(10, 40, 10, 42, u, d, l2, b);
        check("R8", "lock held back early", l + l2, 0);
        period_run(10, 40, 10, 42, u, d, l, b);
        period_run(10, 40, 10, 42, u, d, l, b);
        check("R8", "lock shown after mask", int'(lock_n), 0);
        period_run(10, 40, 10, 70, u, d, l, b);
        check("R8", "unlock immediate", int'(lock_n), 1);
    endtask

    task automatic t_mask_unlock;
        int u, d, l, b;
        do_reset(250, 1'b0, 8);
        period_run(10, 40, 10, 42, u, d, l, b);
        check("R9", "lock immediate", int'(lock_n), 0);
        period_run(10, 40, 10, 70, u, d, l, b);
        check("R9", "short unlock swallowed p1", l, PER);
        period_run(10, 40, 10, 42, u, d, l, b);
        check("R9", "short unlock swallowed p2", l, PER);
        period_run(10, 40, 10, 70, u, d, l, b);
        period_run(10, 40, 10, 70, u, d, l, b);
        check("R9", "unlock held back early", int'(lock_n), 0);
        period_run(10, 40, 10, 70, u, d, l, b);
        period_run(10, 40, 10, 70, u, d, l, b);
        check("R9", "unlock shown after mask", int'(lock_n), 1);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Scenario sequence.
    initial begin
        t_reset();
        t_ref_lead();
        t_fb_lead();
        t_coincident();
        t_lock_basic();
        t_timeout();
        t_mask_lock();
        t_mask_unlock();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule